// File: doc/BRIEF.md
# Truncated-Series Sigmoid Activation Unit

This unit computes the activation of a hardware neuron from its signed fixed-point sum `x`. Neither exponential is looked up or approximated piecewise. Instead the unit builds two truncated power series term by term, one standing for e^-x and one for e^x. The series order `k` is chosen at run time. The unit then forms the activation as a ratio of these sums with a one-bit-per-cycle restoring divider.

A caller presents `x` in Q8.8, an order `k` and a function select, then pulses `start_i`. The unit raises `busy_o` while it works. Each new term comes from the one before it, multiplied by `x` and divided by the term index, so no power or factorial is ever formed. The sums are held in a wide Q64.32 format. When the unit finishes it pulses `done_o` and presents a Q.16 result, which holds until the next computation completes. A sticky overflow flag marks a saturated sum. An error flag marks a zero denominator.

Orders of 10, 20 and 40 are the intended operating points, with 40 suited to the hyperbolic mode over x in [-20, +20]. The unit accepts any order from 0 up to 2^K_W-1.

Top module: `sigact_unit`

## Requirements
- R1: The negative-exponential sum is y = Σ_{n=0..k} (-1)^n·x^n/n!, built with term_n = term_{n-1}·x/n from term_0 = 1. For k = 0, y = 1.
- R2: The positive-exponential sum is z = Σ_{n=0..k} x^n/n! over the same indices. For k = 0 the hyperbolic result is exactly 0.
- R3: With `mode_i` = 0 (hyperbolic), the result is (y − z)/(y + z) in Q.16, truncated toward zero by at most a few LSB.
- R4: With `mode_i` = 1 (logistic), the result is 1/(1 + y) in Q.16. For k = 0 it is exactly 32768.
- R5: `x_i` is signed Q8.8 and `k_i` is an unsigned run-time order. Orders 10, 20 and 40 give the series value for x between −20 and +20. At k = 40, x = 20 in hyperbolic mode, the result lies within 2 LSB of −65536.
- R6: If any term or sum leaves the accumulator range, the value saturates and `ovf_o` reads 1. `ovf_o` stays 1 until the next accepted start, and a run with no saturation leaves it 0.
- R7: A zero denominator forces the result to 0 and sets `err_o` to 1. Otherwise `err_o` is 0 at completion.
- R8: The result is clamped to [−65536, 65536] in hyperbolic mode and to [0, 65536] in logistic mode.
- R9: When the divider iterates, `done_o` rises k+17 clock edges after the edge that accepts `start_i`: k+1 series cycles, one divider load and 16 quotient cycles.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored. The running computation keeps its operands and its timing.
- R11: `done_o` is high for exactly one cycle, and `result_o` keeps its value until the next completion.
- R12: After reset, `busy_o`, `done_o`, `ovf_o`, `err_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a computation when idle |
| mode_i | input | 1 | 0 = hyperbolic ratio, 1 = logistic |
| x_i | input | X_W (16) | Neuron sum, signed Q8.8 |
| k_i | input | K_W (6) | Series order |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | OUT_F+2 (18) | Signed Q.16 activation |
| ovf_o | output | 1 | Sticky saturation flag of the last run |
| err_o | output | 1 | Zero denominator seen in the last run |

## Verification
The two states hardest to reach from the ports are saturation and an exactly zero denominator. Neither occurs over the intended input range at useful orders. The bench reaches saturation by driving the largest positive Q8.8 value at order 40, so that the term grows past 2^63. It reaches the zero denominator with order 1 and x = 2.0 in logistic mode, where y is exactly −1. The clamp paths come from order-1 runs with |x| = 3, where the unclamped ratio has magnitude 3 or is negative in logistic mode.

// File: rtl/sigact_pkg.sv
package sigact_pkg;
   typedef enum logic {
      ACT_TANH = 1'b0,
      ACT_LOGI = 1'b1
   } act_mode_e;
endpackage

// File: rtl/sigact_series.sv
module sigact_series #(
   parameter int X_W   = 16,
   parameter int X_F   = 8,
   parameter int K_W   = 6,
   parameter int ACC_I = 64,
   parameter int ACC_F = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start_i,
   input  logic signed [X_W-1:0]           x_i,
   input  logic        [K_W-1:0]           k_i,
   output logic                            done_o,
   output logic signed [ACC_I+ACC_F-1:0]   y_o,
   output logic signed [ACC_I+ACC_F-1:0]   z_o,
   output logic                            ovf_o
);
   localparam int ACC_W  = ACC_I + ACC_F;
   localparam int PROD_W = ACC_W + X_W;
   localparam logic signed [ACC_W-1:0]  ACC_ONE = ACC_W'(1) <<< ACC_F;
   localparam logic signed [PROD_W-1:0] LIM_HI  = PROD_W'({1'b0, {(ACC_W-1){1'b1}}});
   localparam logic signed [PROD_W-1:0] LIM_LO  = -LIM_HI - PROD_W'(1);

   function automatic logic signed [ACC_W-1:0] clip(input logic signed [PROD_W-1:0] v);
      if (v > LIM_HI)      return LIM_HI[ACC_W-1:0];
      else if (v < LIM_LO) return LIM_LO[ACC_W-1:0];
      else                 return v[ACC_W-1:0];
   endfunction

   function automatic logic outside(input logic signed [PROD_W-1:0] v);
      return (v > LIM_HI) || (v < LIM_LO);
   endfunction

   logic signed [ACC_W-1:0]  term_q, y_q, z_q, t_next;
   logic signed [X_W-1:0]    x_q;
   logic        [K_W-1:0]    n_q, k_q;
   logic                     run_q, done_q, ovf_q;
   logic signed [PROD_W-1:0] prod, scaled, divisor, step, y_wide, z_wide;
   logic                     step_ovf;

   always_comb begin
      prod    = PROD_W'(term_q) * PROD_W'(x_q);
      scaled  = prod >>> X_F;
      divisor = (n_q == '0) ? PROD_W'(1) : $signed(PROD_W'(n_q));
      step    = scaled / divisor;
      t_next  = clip(step);
      y_wide  = n_q[0] ? (PROD_W'(y_q) - PROD_W'(t_next))
                       : (PROD_W'(y_q) + PROD_W'(t_next));
      z_wide  = PROD_W'(z_q) + PROD_W'(t_next);
      step_ovf = outside(step) | outside(y_wide) | outside(z_wide);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         term_q <= '0;
         y_q    <= '0;
         z_q    <= '0;
         x_q    <= '0;
         n_q    <= '0;
         k_q    <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            term_q <= ACC_ONE;
            y_q    <= ACC_ONE;
            z_q    <= ACC_ONE;
            x_q    <= x_i;
            k_q    <= k_i;
            n_q    <= K_W'(1);
            ovf_q  <= 1'b0;
            run_q  <= (k_i != '0);
            done_q <= (k_i == '0);
         end else if (run_q) begin
            term_q <= t_next;
            y_q    <= clip(y_wide);
            z_q    <= clip(z_wide);
            ovf_q  <= ovf_q | step_ovf;
            n_q    <= n_q + K_W'(1);
            if (n_q == k_q) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign y_o    = y_q;
   assign z_o    = z_q;
   assign ovf_o  = ovf_q;
endmodule

// File: rtl/sigact_ratio.sv
module sigact_ratio #(
   parameter int ACC_W = 96,
   parameter int ACC_F = 32,
   parameter int OUT_F = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     log_i,
   input  logic signed [ACC_W-1:0]  y_i,
   input  logic signed [ACC_W-1:0]  z_i,
   output logic                     done_o,
   output logic signed [OUT_F+1:0]  res_o,
   output logic                     err_o
);
   localparam int DW    = ACC_W + 1;
   localparam int OUT_W = OUT_F + 2;
   localparam int CW    = $clog2(OUT_F + 1);
   localparam logic signed [DW-1:0] D_ONE = DW'(1) <<< ACC_F;
   localparam logic [OUT_W-1:0]     Q_ONE = OUT_W'(1) << OUT_F;

   function automatic logic signed [OUT_W-1:0] finish(input logic [OUT_W-1:0] mag,
                                                      input logic neg, input logic lg);
      if (!neg)    return $signed(mag);
      else if (lg) return '0;
      else         return -$signed(mag);
   endfunction

   logic signed [DW-1:0] num, den;
   logic        [DW-1:0] mag_n, mag_d;
   logic                 sign_neg;

   logic        [DW-1:0]    rem_q, dmag_q, rem_nxt;
   logic        [OUT_F-1:0] q_q, q_nxt;
   logic        [CW-1:0]    cnt_q;
   logic                    run_q, neg_q, log_q, done_q, err_q;
   logic signed [OUT_W-1:0] res_q;
   logic        [DW:0]      r2, r_sub;
   logic                    ge;

   always_comb begin
      if (log_i) begin
         num = D_ONE;
         den = D_ONE + DW'(y_i);
      end else begin
         num = DW'(y_i) - DW'(z_i);
         den = DW'(y_i) + DW'(z_i);
      end
      mag_n    = num[DW-1] ? DW'(-num) : DW'(num);
      mag_d    = den[DW-1] ? DW'(-den) : DW'(den);
      sign_neg = num[DW-1] ^ den[DW-1];
      r2       = {rem_q, 1'b0};
      r_sub    = r2 - {1'b0, dmag_q};
      ge       = (r2 >= {1'b0, dmag_q});
      rem_nxt  = ge ? r_sub[DW-1:0] : r2[DW-1:0];
      q_nxt    = {q_q[OUT_F-2:0], ge};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         dmag_q <= '0;
         q_q    <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         neg_q  <= 1'b0;
         log_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         res_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            log_q  <= log_i;
            neg_q  <= sign_neg;
            dmag_q <= mag_d;
            rem_q  <= mag_n;
            q_q    <= '0;
            cnt_q  <= CW'(OUT_F);
            if (den == '0) begin
               res_q  <= '0;
               err_q  <= 1'b1;
               done_q <= 1'b1;
               run_q  <= 1'b0;
            end else if (mag_n >= mag_d) begin
               err_q  <= 1'b0;
               res_q  <= finish(Q_ONE, sign_neg, log_i);
               done_q <= 1'b1;
               run_q  <= 1'b0;
            end else begin
               err_q  <= 1'b0;
               run_q  <= 1'b1;
            end
         end else if (run_q) begin
            rem_q <= rem_nxt;
            q_q   <= q_nxt;
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
               res_q  <= finish({2'b00, q_nxt}, neg_q, log_q);
            end
         end
      end
   end

   assign done_o = done_q;
   assign res_o  = res_q;
   assign err_o  = err_q;
endmodule

// File: rtl/sigact_unit.sv
module sigact_unit
   import sigact_pkg::*;
#(
   parameter int X_W   = 16,
   parameter int X_F   = 8,
   parameter int K_W   = 6,
   parameter int ACC_I = 64,
   parameter int ACC_F = 32,
   parameter int OUT_F = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic                    mode_i,
   input  logic signed [X_W-1:0]   x_i,
   input  logic        [K_W-1:0]   k_i,
   output logic                    busy_o,
   output logic                    done_o,
   output logic signed [OUT_F+1:0] result_o,
   output logic                    ovf_o,
   output logic                    err_o
);
   localparam int ACC_W = ACC_I + ACC_F;

   initial begin
      assert (X_F >= 1 && X_F < X_W) else $error("X_F must lie inside X_W");
      assert (ACC_F >= X_F) else $error("ACC_F must not be below X_F");
      assert (OUT_F >= 2 && OUT_F < ACC_F) else $error("OUT_F out of range");
      assert (K_W >= 1 && K_W <= 8) else $error("K_W out of range");
   end

   act_mode_e              mode_q;
   logic                   busy_q, accept, is_log;
   logic                   ser_done, div_done;
   logic signed [ACC_W-1:0] y_sum, z_sum;

   assign accept = start_i & ~busy_q;
   assign is_log = (mode_q == ACT_LOGI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         mode_q <= ACT_TANH;
      end else if (accept) begin
         busy_q <= 1'b1;
         mode_q <= act_mode_e'(mode_i);
      end else if (div_done) begin
         busy_q <= 1'b0;
      end
   end

   sigact_series #(
      .X_W(X_W), .X_F(X_F), .K_W(K_W), .ACC_I(ACC_I), .ACC_F(ACC_F)
   ) u_series (
      .clk(clk), .rst_n(rst_n), .start_i(accept), .x_i(x_i), .k_i(k_i),
      .done_o(ser_done), .y_o(y_sum), .z_o(z_sum), .ovf_o(ovf_o)
   );

   sigact_ratio #(
      .ACC_W(ACC_W), .ACC_F(ACC_F), .OUT_F(OUT_F)
   ) u_ratio (
      .clk(clk), .rst_n(rst_n), .start_i(ser_done), .log_i(is_log),
      .y_i(y_sum), .z_i(z_sum),
      .done_o(div_done), .res_o(result_o), .err_o(err_o)
   );

   assign busy_o = busy_q;
   assign done_o = div_done;
endmodule

// File: rtl/sigact_unit_chk.sv
module sigact_unit_chk #(
   parameter int OUT_F = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start_i,
   input logic                    busy_o,
   input logic                    done_o,
   input logic signed [OUT_F+1:0] result_o,
   input logic                    err_o,
   input logic                    log_sel
);
   localparam logic signed [OUT_F+1:0] P_ONE = (OUT_F+2)'(1) <<< OUT_F;

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));

   p_range_logi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && log_sel) |-> (result_o >= 0 && result_o <= P_ONE));

   p_range_tanh_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !log_sel) |-> (result_o >= -P_ONE && result_o <= P_ONE));

   p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (result_o == 0));

   p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   p_busy_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind sigact_unit sigact_unit_chk #(.OUT_F(OUT_F)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
   .done_o(done_o), .result_o(result_o), .err_o(err_o), .log_sel(is_log)
);

// File: tb/tb_sigact_unit.sv
module tb_sigact_unit;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start_i = 1'b0;
   logic               mode_i = 1'b0;
   logic signed [15:0] x_i = '0;
   logic        [5:0]  k_i = '0;
   logic               busy_o, done_o, ovf_o, err_o;
   logic signed [17:0] result_o;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   sigact_unit dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .x_i(x_i), .k_i(k_i), .busy_o(busy_o), .done_o(done_o),
      .result_o(result_o), .ovf_o(ovf_o), .err_o(err_o)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp, input int tol);
      int d;
      n_tests++;
      d = act - exp;
      if (d < 0) d = -d;
      if (d > tol) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic real ref_val(input bit m, input int xq, input int k);
      real x, t, y, z, r;
      x = xq / 256.0;
      t = 1.0; y = 1.0; z = 1.0;
      for (int n = 1; n <= k; n++) begin
         t = t * x / n;
         z = z + t;
         y = (n % 2 == 1) ? y - t : y + t;
      end
      if (m) r = 1.0 / (1.0 + y);
      else   r = (y - z) / (y + z);
      if (r > 1.0) r = 1.0;
      if (m && r < 0.0) r = 0.0;
      if (!m && r < -1.0) r = -1.0;
      return r * 65536.0;
   endfunction

   task automatic run_op(input bit m, input int xq, input int k, output int lat);
      @(negedge clk);
      start_i = 1'b1; mode_i = m; x_i = 16'(xq); k_i = 6'(k);
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (!done_o && lat < 3000) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic check_ref(input string req, input bit m, input int xq, input int k);
      int lat;
      run_op(m, xq, k, lat);
      check(req, int'(result_o), $rtoi(ref_val(m, xq, k)), 3);
   endtask

   task automatic t_reset;
      check("R12 busy", int'(busy_o), 0, 0);
      check("R12 done", int'(done_o), 0, 0);
      check("R12 ovf", int'(ovf_o), 0, 0);
      check("R12 err", int'(err_o), 0, 0);
      check("R12 result", int'(result_o), 0, 0);
   endtask

   task automatic t_hyperbolic;
      check_ref("R3 R1 R2 x=0.5 k=10", 1'b0, 128, 10);
      check_ref("R3 R5 x=-3 k=20", 1'b0, -768, 20);
      check_ref("R3 R5 x=1.25 k=40", 1'b0, 320, 40);
      check_ref("R5 x=20 k=40", 1'b0, 5120, 40);
      check("R5 x=20 k=40 near -1", int'(result_o), -65536, 2);
      check("R6 no saturation", int'(ovf_o), 0, 0);
   endtask

   task automatic t_logistic;
      check_ref("R4 R1 x=2 k=20", 1'b1, 512, 20);
      check_ref("R4 x=-10 k=10", 1'b1, -2560, 10);
      check_ref("R4 x=-0.75 k=40", 1'b1, -192, 40);
   endtask

   task automatic t_order_zero;
      int lat;
      run_op(1'b0, 1000, 0, lat);
      check("R2 k=0 hyperbolic", int'(result_o), 0, 0);
      run_op(1'b1, -1000, 0, lat);
      check("R4 k=0 logistic", int'(result_o), 32768, 0);
      check("R9 k=0 latency", lat, 17, 0);
   endtask

   task automatic t_clamp;
      int lat;
      run_op(1'b0, 768, 1, lat);
      check("R8 hyperbolic clamp low", int'(result_o), -65536, 0);
      run_op(1'b0, -768, 1, lat);
      check("R8 hyperbolic clamp high", int'(result_o), 65536, 0);
      run_op(1'b1, 768, 1, lat);
      check("R8 logistic clamp zero", int'(result_o), 0, 0);
      check("R7 err clear", int'(err_o), 0, 0);
   endtask

   task automatic t_zero_den;
      int lat;
      run_op(1'b1, 512, 1, lat);
      check("R7 zero denominator result", int'(result_o), 0, 0);
      check("R7 zero denominator err", int'(err_o), 1, 0);
   endtask

   task automatic t_overflow;
      int lat;
      run_op(1'b0, 32767, 40, lat);
      check("R6 saturation flagged", int'(ovf_o), 1, 0);
      repeat (5) @(negedge clk);
      check("R6 flag held", int'(ovf_o), 1, 0);
      run_op(1'b0, 256, 10, lat);
      check("R6 flag cleared by clean run", int'(ovf_o), 0, 0);
   endtask

   task automatic t_latency;
      int lat;
      run_op(1'b0, 128, 10, lat);
      check("R9 latency k=10", lat, 27, 0);
      run_op(1'b1, 128, 40, lat);
      check("R9 latency k=40", lat, 57, 0);
   endtask

   task automatic t_busy_ignore;
      int lat;
      int extra;
      @(negedge clk);
      start_i = 1'b1; mode_i = 1'b0; x_i = 16'sd128; k_i = 6'd10;
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      repeat (3) begin @(negedge clk); lat++; end
      start_i = 1'b1; mode_i = 1'b1; x_i = 16'sd768; k_i = 6'd1;
      @(negedge clk);
      lat++;
      start_i = 1'b0;
      while (!done_o && lat < 3000) begin
         @(negedge clk);
         lat++;
      end
      check("R10 timing kept", lat, 27, 0);
      check("R10 operands kept", int'(result_o), $rtoi(ref_val(1'b0, 128, 10)), 3);
      extra = 0;
      repeat (40) begin
         @(negedge clk);
         if (done_o) extra++;
      end
      check("R10 no second completion", extra, 0, 0);
   endtask

   task automatic t_done_pulse;
      int lat;
      int held;
      run_op(1'b1, 512, 20, lat);
      held = int'(result_o);
      @(negedge clk);
      check("R11 done one cycle", int'(done_o), 0, 0);
      repeat (10) @(negedge clk);
      check("R11 result held", int'(result_o), held, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_hyperbolic();
      t_logistic();
      t_order_zero();
      t_clamp();
      t_zero_den();
      t_overflow();
      t_latency();
      t_busy_ignore();
      t_done_pulse();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule